// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache

This block is a small data cache placed between a processor's load/store port and a slow main memory that is addressed by word. It holds 32 data words as four sets, each with two ways, and each way holds a line of four words. A load that finds its line in the cache returns data in the same cycle, with no stall. A load that misses raises a stall. While the stall is high, the cache reads the whole line from memory one word at a time. The miss costs a fixed penalty of five stall cycles. After the penalty the held request completes as a hit.

Stores pass straight through to memory in the cycle they are presented. A store that finds its line cached also updates the cached word. A store that misses leaves the cache unchanged. Each set has one replacement bit. A line fill goes to an empty way first. When both ways are full, it evicts the way used less recently. A free-running 32-bit counter adds up every stall cycle, so the total delay of a workload can be read at the port.

The requester must hold `req_valid`, `req_write`, `req_addr` and `req_wdata` steady while `stall` is high. The access completes at the first rising edge on which `stall` is low.

Top module: `dcache2w`

## Requirements
- R1: After reset every line is invalid, `stall_count` is 0, and `stall`, `mem_rd` and `mem_wr` are low while no request is presented. The first load to any address after reset misses.
- R2: A load whose line is resident gives `stall` = 0 in the same cycle. `rd_data` equals the current memory value of the addressed word, and `mem_rd` stays low.
- R3: A load whose line is absent holds `stall` high for exactly MEM_LAT = 5 consecutive cycles. During them it asserts `mem_rd` for four consecutive cycles, at line addresses with offsets 0, 1, 2 and 3 in that order. The following cycle then returns the word as a hit.
- R4: Every store in a cycle without stall drives `mem_wr` = 1 in that same cycle, with `mem_addr` = `req_addr` and `mem_wdata` = `req_wdata`. It never stalls, and `mem_rd` and `mem_wr` are never high together.
- R5: A store to an absent line does not allocate it, so a later load of that address misses.
- R6: A store to a resident line updates the cached word, so a later load hits and returns the stored data.
- R7: Word address bits [1:0] select the word in the line, bits [3:2] select the set, and bits [15:4] form the tag. Lines in different sets never displace each other.
- R8: A fill goes to an invalid way of the set when there is one, so two lines with the same set index can be resident together.
- R9: When both ways are valid, a fill evicts the least recently used way. A load hit, a store hit and a fill each count as a use of their way.
- R10: `stall_count` equals the total number of cycles in which `stall` was high since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 16 | Word address of the request |
| req_wdata | input | 32 | Store data |
| rd_data | output | 32 | Load data, valid when a load is presented and stall is low |
| stall | output | 1 | Requester must hold its request |
| mem_rd | output | 1 | Memory read strobe (line fill) |
| mem_wr | output | 1 | Memory write strobe (write-through) |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, same cycle as mem_rd |
| stall_count | output | 32 | Running total of stall cycles |

## Verification
The hardest case to reach is eviction order. It requires a set whose two ways are both valid, whose replacement bit was last moved by a particular kind of use, and then a third tag arriving in that set. Directed sequences build this case for load hits, for store hits and for fills. After that, random traffic confined to 128 words (eight tags for each set) creates frequent conflicts. A bench model of the tags, valid bits and replacement bits predicts each hit and miss, and the length of every stall is measured and compared with the prediction.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic {FC_IDLE, FC_FILL} fc_state_e;

  // Replacement choice: first empty way, else the way the LRU bit names.
  function automatic logic pick_victim(input logic [1:0] vld, input logic lru);
    if (!vld[0]) return 1'b0;
    if (!vld[1]) return 1'b1;
    return lru;
  endfunction
endpackage

// File: rtl/dc_tagstore.sv
module dc_tagstore #(
  parameter int SETS  = 4,
  parameter int SET_W = 2,
  parameter int TAG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             fill_en,
  input  logic [SET_W-1:0] fill_set,
  input  logic             fill_way,
  input  logic [TAG_W-1:0] fill_tag,
  output logic [1:0]       hit_vec,
  output logic [1:0]       set_valid
);
  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  vld_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= '0;
      end else if (fill_en && (fill_way == 1'(w))) begin
        vld_q[fill_set]  <= 1'b1;
        tag_q[fill_set]  <= fill_tag;
      end
    end

    assign set_valid[w] = vld_q[lk_set];
    assign hit_vec[w]   = vld_q[lk_set] && (tag_q[lk_set] == lk_tag);
  end
endmodule

// File: rtl/dc_lru.sv
module dc_lru #(
  parameter int SETS  = 4,
  parameter int SET_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic             touch_way,
  input  logic [SET_W-1:0] q_set,
  input  logic [1:0]       q_valid,
  output logic             victim
);
  import dc_pkg::*;
  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lru_q <= '0;
    else if (touch_en) lru_q[touch_set] <= ~touch_way;
  end

  assign victim = pick_victim(q_valid, lru_q[q_set]);
endmodule

// File: rtl/dc_fill_ctl.sv
module dc_fill_ctl #(
  parameter int MEM_LAT    = 5,
  parameter int LINE_WORDS = 4,
  parameter int CNT_W      = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          miss,
  output logic                          busy,
  output logic                          fill_we,
  output logic [$clog2(LINE_WORDS)-1:0] fill_idx,
  output logic                          fill_done,
  output logic                          stall,
  output logic [CNT_W-1:0]              stall_count
);
  import dc_pkg::*;
  localparam int CW  = $clog2(MEM_LAT);
  localparam int OFW = $clog2(LINE_WORDS);
  localparam logic [CW-1:0] LAST_WORD = CW'(LINE_WORDS - 1);
  localparam logic [CW-1:0] END_CNT   = CW'(MEM_LAT - 2);

  fc_state_e     st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= FC_IDLE;
      cnt_q <= '0;
    end else if (st_q == FC_IDLE) begin
      cnt_q <= '0;
      if (miss) st_q <= FC_FILL;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == END_CNT) st_q <= FC_IDLE;
    end
  end

  assign busy      = (st_q == FC_FILL);
  assign fill_we   = busy && (cnt_q <= LAST_WORD);
  assign fill_idx  = cnt_q[OFW-1:0];
  assign fill_done = busy && (cnt_q == LAST_WORD);
  assign stall     = busy || miss;

  always_ff @(posedge clk) begin
    if (!rst_n) stall_count <= '0;
    else if (stall) stall_count <= stall_count + 1'b1;
  end
endmodule

// File: rtl/dcache2w.sv
module dcache2w #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int SETS       = 4,
  parameter int LINE_WORDS = 4,
  parameter int MEM_LAT    = 5,
  parameter int CNT_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              stall,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  stall_count
);
  localparam int OFW   = $clog2(LINE_WORDS);
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - SET_W - OFW;

  // address fields
  logic [OFW-1:0]   a_off;
  logic [SET_W-1:0] a_set;
  logic [TAG_W-1:0] a_tag;
  assign a_off = req_addr[OFW-1:0];
  assign a_set = req_addr[OFW +: SET_W];
  assign a_tag = req_addr[ADDR_W-1 -: TAG_W];

  // named events
  logic [1:0]  hit_vec, set_valid;
  logic        hit, hit_way, victim, busy, miss;
  logic        rd_hit, wr_hit, fill_we, fill_done;
  logic [OFW-1:0] fill_idx;

  assign hit     = |hit_vec;
  assign hit_way = hit_vec[1];
  assign miss    = req_valid && !req_write && !hit && !busy;
  assign rd_hit  = req_valid && !req_write && hit && !busy;
  assign wr_hit  = req_valid && req_write && hit && !busy;

  // latched miss line
  logic [SET_W-1:0] m_set_q;
  logic [TAG_W-1:0] m_tag_q;
  logic             m_way_q;
  always_ff @(posedge clk) begin
    if (miss) begin
      m_set_q <= a_set;
      m_tag_q <= a_tag;
      m_way_q <= victim;
    end
  end

  dc_tagstore #(.SETS(SETS), .SET_W(SET_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .lk_set(a_set), .lk_tag(a_tag),
    .fill_en(fill_done), .fill_set(m_set_q), .fill_way(m_way_q), .fill_tag(m_tag_q),
    .hit_vec(hit_vec), .set_valid(set_valid));

  dc_lru #(.SETS(SETS), .SET_W(SET_W)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .touch_en(rd_hit || wr_hit || fill_done),
    .touch_set(fill_done ? m_set_q : a_set),
    .touch_way(fill_done ? m_way_q : hit_way),
    .q_set(a_set), .q_valid(set_valid), .victim(victim));

  dc_fill_ctl #(.MEM_LAT(MEM_LAT), .LINE_WORDS(LINE_WORDS), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .miss(miss), .busy(busy), .fill_we(fill_we),
    .fill_idx(fill_idx), .fill_done(fill_done), .stall(stall), .stall_count(stall_count));

  // data array: 2 ways x SETS x LINE_WORDS
  logic [DATA_W-1:0] data_q [2][SETS][LINE_WORDS];
  always_ff @(posedge clk) begin
    if (fill_we) data_q[m_way_q][m_set_q][fill_idx] <= mem_rdata;
    else if (wr_hit) data_q[hit_way][a_set][a_off] <= req_wdata;
  end

  assign rd_data   = data_q[hit_way][a_set][a_off];
  assign mem_rd    = fill_we;
  assign mem_wr    = req_valid && req_write && !busy;
  assign mem_addr  = busy ? {m_tag_q, m_set_q, fill_idx} : req_addr;
  assign mem_wdata = req_wdata;
endmodule

// File: rtl/dcache2w_chk.sv
module dcache2w_chk #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int MEM_LAT = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              stall,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [1:0]        hit_vec,
  input logic              busy
);
  logic [7:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else if (stall) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  assert_hit_no_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !busy && (|hit_vec)) |-> (!stall && !mem_rd));

  assert_stall_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (run_q < 8'(MEM_LAT)));

  assert_stall_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> (run_q == 8'(MEM_LAT)));

  assert_fill_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  assert_write_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !stall) |->
      (mem_wr && mem_addr == req_addr && mem_wdata == req_wdata));

  assert_port_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_single_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

bind dcache2w dcache2w_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_LAT(MEM_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .stall(stall), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .hit_vec(hit_vec), .busy(busy));

// File: tb/tb_dcache2w.sv
module tb_dcache2w;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data, mem_wdata, mem_rdata;
  logic        stall, mem_rd, mem_wr;
  logic [15:0] mem_addr;
  logic [31:0] stall_count;

  always #5 clk = ~clk;

  dcache2w dut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data), .stall(stall),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .stall_count(stall_count));

  // main memory model (256 words used)
  logic [31:0] mem_arr [256];
  assign mem_rdata = mem_arr[mem_addr[7:0]];
  always @(posedge clk) if (mem_wr) mem_arr[mem_addr[7:0]] <= mem_wdata;

  // expected state from the requirements
  logic [31:0] exp_mem [256];
  logic [11:0] m_tag [2][4];
  bit          m_vld [2][4];
  bit          m_lru [4];
  int          exp_stalls = 0;
  int          total = 0, bad = 0;
  bit          done = 0;

  function automatic logic [31:0] init_word(input int a);
    return 32'(a) * 32'h9E3779B1 + 32'h1234567;
  endfunction
  function automatic int f_set(input logic [15:0] a); return int'(a[3:2]); endfunction
  function automatic logic [11:0] f_tag(input logic [15:0] a); return a[15:4]; endfunction

  function automatic int model_way(input logic [15:0] a);
    for (int w = 0; w < 2; w++)
      if (m_vld[w][f_set(a)] && m_tag[w][f_set(a)] == f_tag(a)) return w;
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // one access; tag names the requirement under test
  task automatic access(input bit w, input logic [15:0] a, input logic [31:0] d,
                        input string tag);
    int way, n, k, s;
    bit ok;
    way = model_way(a);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    #1;
    n = 0; k = 0; ok = 1;
    while (stall && n < 20) begin
      if (mem_rd) begin
        if (mem_addr != {a[15:2], 2'(k)}) ok = 0;
        k++;
      end
      n++;
      @(negedge clk); #1;
    end
    exp_stalls += n;
    if (w) begin
      check(n == 0, tag, "store stall cycles", n, 0);
      check(mem_wr && mem_addr == a && mem_wdata == d, tag, "write-through addr",
            mem_wr ? mem_addr : 16'hFFFF, a);
    end else begin
      check(n == (way < 0 ? 5 : 0), tag, "load stall cycles", n, way < 0 ? 5 : 0);
      if (way < 0) check(ok && k == 4, tag, "fill word sequence", k, 4);
      else check(!mem_rd, tag, "no fill on hit", mem_rd, 0);
      check(rd_data == exp_mem[a[7:0]], tag, "load data", rd_data, exp_mem[a[7:0]]);
    end
    @(posedge clk);
    s = f_set(a);
    if (w) begin
      exp_mem[a[7:0]] = d;
      if (way >= 0) m_lru[s] = (way == 0);
    end else if (way >= 0) begin
      m_lru[s] = (way == 0);
    end else begin
      if (!m_vld[0][s]) way = 0;
      else if (!m_vld[1][s]) way = 1;
      else way = m_lru[s] ? 1 : 0;
      m_vld[way][s] = 1; m_tag[way][s] = f_tag(a); m_lru[s] = (way == 0);
    end
    #1 req_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem_arr[i] = init_word(i); exp_mem[i] = init_word(i);
    end
    for (int w = 0; w < 2; w++) for (int s = 0; s < 4; s++) m_vld[w][s] = 0;
    for (int s = 0; s < 4; s++) m_lru[s] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    // R1: reset state
    check(stall_count == 0, "R1", "stall_count after reset", stall_count, 0);
    check(!stall && !mem_rd && !mem_wr, "R1", "idle strobes",
          {stall, mem_rd, mem_wr}, 0);
    access(0, 16'h0005, 0, "R1_R3");          // first load misses
    access(0, 16'h0006, 0, "R2");             // same line hits
    access(0, 16'h0009, 0, "R7");             // set 2 miss
    access(0, 16'h0005, 0, "R7");             // set 1 still resident
    access(0, 16'h0015, 0, "R8");             // set 1, second way
    access(0, 16'h0004, 0, "R8");             // both resident
    access(0, 16'h0017, 0, "R8");
    // R9: load hit makes 0x0015 newest, fill of 0x0025 evicts 0x0005
    access(0, 16'h0025, 0, "R9");
    access(0, 16'h0016, 0, "R9");             // hit
    access(0, 16'h0005, 0, "R9");             // miss, evicts 0x0025 line
    // R9: store hit counts as use
    access(1, 16'h0014, 32'hDEADBEEF, "R6_R9");
    access(0, 16'h0035, 0, "R9");             // evicts 0x0005 line
    access(0, 16'h0014, 0, "R6");             // hit with stored data
    access(0, 16'h0004, 0, "R9");             // miss
    // R5: store miss does not allocate
    access(1, 16'h0042, 32'h0BADF00D, "R4_R5");
    access(0, 16'h0042, 0, "R5");             // misses, fetches stored value
    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      logic [15:0] ra;
      bit rw;
      ra = 16'($urandom % 128);
      rw = ($urandom % 10) < 3;
      access(rw, ra, $urandom, rw ? "R4_R6" : "R2_R3_R9");
    end
    @(negedge clk); #1;
    check(stall_count == 32'(exp_stalls), "R10", "stall_count total",
          stall_count, exp_stalls);
    done = 1;
    summary();
  end
endmodule